// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits between two independent access ports and the shared memory array they both use. Every access from either port goes straight through to its own side of the array, unchanged and in the same cycle. The block also watches both ports for accesses to two reserved words at the top of the address space. Those two words serve as mailboxes, one owned by each port.

The right port notifies the left port by writing to the left mailbox at address `DEPTH-2`. That write pulls the left port's active-low interrupt low. The left port acknowledges by reading the same address, which releases the interrupt. The same scheme runs in the opposite direction: a left-port write to the right mailbox at `DEPTH-1` interrupts the right port, and a right-port read of `DEPTH-1` clears it.

Mailbox words are also ordinary storage, so the message written there can be read back by the receiver in the same read that acknowledges it. Each interrupt flag is a two-state machine with these states and transitions:
- `MBX_IDLE`: interrupt released.
- `MBX_PENDING`: interrupt asserted.
- `T_POST` moves `MBX_IDLE` to `MBX_PENDING`.
- `T_ACK` moves `MBX_PENDING` back to `MBX_IDLE`.
- Every other case stays in the current state (`T_HOLD`).

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst_n` is low, both `l_irq_n` and `r_irq_n` are high (deasserted).
- R2: A right-port write (`r_ce`=1, `r_we`=1) to address `DEPTH-2` drives `l_irq_n` low from the next clock edge.
- R3: A left-port read (`l_ce`=1, `l_we`=0) of address `DEPTH-2` returns `l_irq_n` high from the next clock edge.
- R4: A left-port write to address `DEPTH-1` drives `r_irq_n` low from the next clock edge.
- R5: A right-port read of address `DEPTH-1` returns `r_irq_n` high from the next clock edge.
- R6: When a set and a clear of the same interrupt arrive in the same cycle, the interrupt ends asserted (low).
- R7: The following leave both interrupts unchanged:
  - a port writing its own mailbox;
  - a port reading the other port's mailbox;
  - any access with the chip enable (`*_ce`) low.
- R8: Each port's `ce`, `we`, `addr` and `wdata` appear unchanged on the matching `arr_*` outputs in the same cycle, and `arr_*_rdata` appears on `*_rdata`; this applies to mailbox addresses too.
- R9: With no setting or clearing access, each interrupt keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce | input | 1 | Left port chip enable, active high |
| l_we | input | 1 | Left port write strobe (1 write, 0 read) |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read data from the array |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_ce | input | 1 | Right port chip enable, active high |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read data from the array |
| r_irq_n | output | 1 | Right port interrupt, active low |
| arr_l_ce | output | 1 | Array left side enable |
| arr_l_we | output | 1 | Array left side write strobe |
| arr_l_addr | output | AW | Array left side address |
| arr_l_wdata | output | DW | Array left side write data |
| arr_l_rdata | input | DW | Array left side read data |
| arr_r_ce | output | 1 | Array right side enable |
| arr_r_we | output | 1 | Array right side write strobe |
| arr_r_addr | output | AW | Array right side address |
| arr_r_wdata | output | DW | Array right side write data |
| arr_r_rdata | input | DW | Array right side read data |

## Verification
The array-side signals and the read data are combinational, so they are checked one time step after the inputs change, within the same cycle. Setting or clearing an interrupt goes through exactly one register, so the effect is due at the first rising edge after the access is presented. The bench drives each access on a falling edge and samples both interrupts one step after the following rising edge. Reset is checked while `rst_n` is held low, both at start-up and after both flags have been set.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
    typedef enum logic {
        MBX_IDLE    = 1'b0,
        MBX_PENDING = 1'b1
    } mbx_state_e;

    localparam int unsigned PORT_L = 0;
    localparam int unsigned PORT_R = 1;
    localparam int unsigned NPORTS = 2;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int unsigned AW       = 15,
    parameter int unsigned OWN_BOX  = 0,
    parameter int unsigned PEER_BOX = 1
) (
    input  logic          ce,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output logic          post_peer,
    output logic          ack_own
);
    localparam logic [AW-1:0] OWN_A  = AW'(OWN_BOX);
    localparam logic [AW-1:0] PEER_A = AW'(PEER_BOX);

    always_comb begin
        post_peer = ce && we && (addr == PEER_A);
        ack_own   = ce && !we && (addr == OWN_A);
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic ack,
    output logic irq_n
);
    mbx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MBX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MBX_IDLE:    if (post) state_d = MBX_PENDING;
            MBX_PENDING: if (ack && !post) state_d = MBX_IDLE;
            default:     state_d = MBX_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MBX_PENDING: irq_n = 1'b0;
            default:     irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 32768,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_irq_n,
    input  logic          r_ce,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_irq_n,
    output logic          arr_l_ce,
    output logic          arr_l_we,
    output logic [AW-1:0] arr_l_addr,
    output logic [DW-1:0] arr_l_wdata,
    input  logic [DW-1:0] arr_l_rdata,
    output logic          arr_r_ce,
    output logic          arr_r_we,
    output logic [AW-1:0] arr_r_addr,
    output logic [DW-1:0] arr_r_wdata,
    input  logic [DW-1:0] arr_r_rdata
);
    localparam int unsigned BOX_L = DEPTH - 2;
    localparam int unsigned BOX_R = DEPTH - 1;

    logic [NPORTS-1:0]          ce_v, we_v, post_v, ack_v, irq_n_v;
    logic [NPORTS-1:0][AW-1:0]  addr_v;

    always_comb begin
        ce_v[PORT_L]   = l_ce;
        we_v[PORT_L]   = l_we;
        addr_v[PORT_L] = l_addr;
        ce_v[PORT_R]   = r_ce;
        we_v[PORT_R]   = r_we;
        addr_v[PORT_R] = r_addr;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int unsigned OWN  = (p == PORT_L) ? BOX_L : BOX_R;
        localparam int unsigned PEER = (p == PORT_L) ? BOX_R : BOX_L;

        mbx_port_decode #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) dec_i (
            .ce        (ce_v[p]),
            .we        (we_v[p]),
            .addr      (addr_v[p]),
            .post_peer (post_v[p]),
            .ack_own   (ack_v[p])
        );

        mbx_flag_fsm flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .post  (post_v[NPORTS-1-p]),
            .ack   (ack_v[p]),
            .irq_n (irq_n_v[p])
        );
    end

    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];

    assign arr_l_ce    = l_ce;
    assign arr_l_we    = l_we;
    assign arr_l_addr  = l_addr;
    assign arr_l_wdata = l_wdata;
    assign l_rdata     = arr_l_rdata;
    assign arr_r_ce    = r_ce;
    assign arr_r_we    = r_we;
    assign arr_r_addr  = r_addr;
    assign arr_r_wdata = r_wdata;
    assign r_rdata     = arr_r_rdata;
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned DEPTH = 32768,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_ce,
    input logic          l_we,
    input logic [AW-1:0] l_addr,
    input logic          l_irq_n,
    input logic          r_ce,
    input logic          r_we,
    input logic [AW-1:0] r_addr,
    input logic          r_irq_n
);
    localparam logic [AW-1:0] LBOX = AW'(DEPTH - 2);
    localparam logic [AW-1:0] RBOX = AW'(DEPTH - 1);

    logic set_l, clr_l, set_r, clr_r;
    assign set_l = r_ce && r_we && (r_addr == LBOX);
    assign clr_l = l_ce && !l_we && (l_addr == LBOX);
    assign set_r = l_ce && l_we && (l_addr == RBOX);
    assign clr_r = r_ce && !r_we && (r_addr == RBOX);

    AST_RESET_RELEASED: assert property (@(posedge clk) !rst_n |-> (l_irq_n && r_irq_n)); // R1
    AST_L_SET: assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !l_irq_n); // R2
    AST_L_CLR: assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> l_irq_n); // R3
    AST_R_SET: assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !r_irq_n); // R4
    AST_R_CLR: assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> r_irq_n); // R5
    AST_L_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!set_l && !clr_l) |=> $stable(l_irq_n)); // R9
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!set_r && !clr_r) |=> $stable(r_irq_n)); // R9
endmodule

bind mbx_irq_top mbx_irq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce    (l_ce),
    .l_we    (l_we),
    .l_addr  (l_addr),
    .l_irq_n (l_irq_n),
    .r_ce    (r_ce),
    .r_we    (r_we),
    .r_addr  (r_addr),
    .r_irq_n (r_irq_n)
);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb_top;
    localparam int unsigned DEPTH  = 32768;
    localparam int unsigned DW     = 8;
    localparam int unsigned AW     = $clog2(DEPTH);
    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned NVEC   = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          l_ce, l_we, r_ce, r_we;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_irq_n, r_irq_n;
    logic          arr_l_ce, arr_l_we, arr_r_ce, arr_r_we;
    logic [AW-1:0] arr_l_addr, arr_r_addr;
    logic [DW-1:0] arr_l_wdata, arr_r_wdata, arr_l_rdata, arr_r_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_irq_n(r_irq_n),
        .arr_l_ce(arr_l_ce), .arr_l_we(arr_l_we), .arr_l_addr(arr_l_addr),
        .arr_l_wdata(arr_l_wdata), .arr_l_rdata(arr_l_rdata),
        .arr_r_ce(arr_r_ce), .arr_r_we(arr_r_we), .arr_r_addr(arr_r_addr),
        .arr_r_wdata(arr_r_wdata), .arr_r_rdata(arr_r_rdata)
    );

    // vector: {l_ce, l_we, l_sel[1:0], r_ce, r_we, r_sel[1:0], exp_l_irq_n, exp_r_irq_n}
    // sel: 0 = left mailbox (DEPTH-2), 1 = right mailbox (DEPTH-1), 2 = ordinary word
    typedef logic [9:0] vec_t;
    localparam vec_t VEC [NVEC] = '{
        {1'b0,1'b0,2'd2, 1'b0,1'b0,2'd2, 1'b1,1'b1}, // R9 idle
        {1'b0,1'b0,2'd2, 1'b1,1'b1,2'd0, 1'b0,1'b1}, // R2 right posts left
        {1'b0,1'b0,2'd2, 1'b0,1'b0,2'd2, 1'b0,1'b1}, // R9 held
        {1'b1,1'b1,2'd0, 1'b0,1'b0,2'd2, 1'b0,1'b1}, // R7 own-box write
        {1'b0,1'b0,2'd2, 1'b1,1'b0,2'd0, 1'b0,1'b1}, // R7 peer-box read
        {1'b1,1'b0,2'd0, 1'b0,1'b0,2'd2, 1'b1,1'b1}, // R3 left acks
        {1'b1,1'b1,2'd1, 1'b0,1'b0,2'd2, 1'b1,1'b0}, // R4 left posts right
        {1'b0,1'b0,2'd2, 1'b1,1'b1,2'd1, 1'b1,1'b0}, // R7 own-box write
        {1'b0,1'b0,2'd2, 1'b0,1'b0,2'd1, 1'b1,1'b0}, // R7 read with ce low
        {1'b0,1'b0,2'd2, 1'b1,1'b0,2'd1, 1'b1,1'b1}, // R5 right acks
        {1'b1,1'b1,2'd1, 1'b1,1'b1,2'd0, 1'b0,1'b0}, // R2 both post
        {1'b1,1'b1,2'd1, 1'b1,1'b0,2'd1, 1'b0,1'b0}, // R6 right set wins
        {1'b1,1'b0,2'd0, 1'b1,1'b1,2'd0, 1'b0,1'b0}, // R6 left set wins
        {1'b1,1'b0,2'd0, 1'b1,1'b0,2'd1, 1'b1,1'b1}, // R3 both ack
        {1'b1,1'b1,2'd2, 1'b1,1'b1,2'd2, 1'b1,1'b1}  // R7 ordinary writes
    };
    localparam int VTAG [NVEC] = '{9, 2, 9, 7, 7, 3, 4, 7, 7, 5, 2, 6, 6, 3, 7};

    function automatic logic [AW-1:0] sel_addr(input logic [1:0] sel);
        case (sel)
            2'd0:    return AW'(DEPTH - 2);
            2'd1:    return AW'(DEPTH - 1);
            default: return AW'(5);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        l_ce = 1'b0; l_we = 1'b0; l_addr = '0; l_wdata = '0;
        r_ce = 1'b0; r_we = 1'b0; r_addr = '0; r_wdata = '0;
        arr_l_rdata = '0; arr_r_rdata = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        check("R1", {l_irq_n, r_irq_n}, 2'b11);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            l_ce = VEC[i][9]; l_we = VEC[i][8]; l_addr = sel_addr(VEC[i][7:6]);
            r_ce = VEC[i][5]; r_we = VEC[i][4]; r_addr = sel_addr(VEC[i][3:2]);
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d", VTAG[i], i), {l_irq_n, r_irq_n}, {30'd0, VEC[i][1:0]});
        end

        // R8 pass-through on a mailbox address, same cycle
        @(negedge clk);
        l_ce = 1'b1; l_we = 1'b1; l_addr = AW'(DEPTH - 1); l_wdata = 8'hA5;
        r_ce = 1'b1; r_we = 1'b0; r_addr = AW'(DEPTH - 2); r_wdata = 8'h3C;
        arr_l_rdata = 8'h5A; arr_r_rdata = 8'hC3;
        #1;
        check("R8 left ctl", {arr_l_ce, arr_l_we, arr_l_addr}, {1'b1, 1'b1, AW'(DEPTH - 1)});
        check("R8 left wdata", arr_l_wdata, 8'hA5);
        check("R8 right ctl", {arr_r_ce, arr_r_we, arr_r_addr}, {1'b1, 1'b0, AW'(DEPTH - 2)});
        check("R8 right wdata", arr_r_wdata, 8'h3C);
        check("R8 rdata", {l_rdata, r_rdata}, {8'h5A, 8'hC3});
        @(posedge clk);
        #1;
        check("R4 after pass", r_irq_n, 1'b0);

        // R1 reset with both flags pending
        @(negedge clk);
        l_ce = 1'b1; l_we = 1'b1; l_addr = AW'(DEPTH - 1);
        r_ce = 1'b1; r_we = 1'b1; r_addr = AW'(DEPTH - 2);
        @(posedge clk);
        #1;
        check("R2 pre-reset", {l_irq_n, r_irq_n}, 2'b00);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {l_irq_n, r_irq_n}, 2'b11);
        @(posedge clk);
        #1;
        check("R1 held", {l_irq_n, r_irq_n}, 2'b11);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R9 after reset", {l_irq_n, r_irq_n}, 2'b11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule